// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous burst memory uses on each beat of a four-beat burst. A start strobe captures an external start address. After that, the two lowest address bits come from an internal beat counter. The upper bits keep the captured value for the whole burst.

Each advancing clock edge moves the burst one beat forward. An edge without advance is a wait state, and the current address is presented again. An order input chooses between two four-beat patterns. The linear pattern counts up from the start value and wraps around. The interleaved pattern XORs the start value with the beat count. The sequence never stops on its own: advancing past the fourth beat returns to the start address and repeats the pattern.

Both outputs, the full address and the beat index, come straight from registers. They change on the clock edge after the controlling inputs are sampled.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset sets `addr_o` and `beat_o` to zero on the next edge.
- R2: When `proc_go_i` or `ctrl_go_i` (or both) is high at an edge, `addr_o` takes `addr_i` and `beat_o` becomes 0 on that edge.
- R3: A start strobe has priority over `adv_i`. If both are high at the same edge, the load of R2 happens and no step is taken.
- R4: When `adv_i` is high and no strobe is present, `beat_o` increases by one modulo 4.
- R5: When `adv_i` is low and no strobe is present, `addr_o` and `beat_o` keep their values (wait state).
- R6: Between loads, `addr_o[ADDR_W-1:2]` stays equal to the upper bits of the last loaded start address.
- R7: With `order_i` = 0 (linear), a step sets the low two bits of `addr_o` to (start + beat) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R8: With `order_i` = 1 (interleaved), a step sets the low two bits to start XOR beat. A start of 10 gives 10, 11, 00, 01. A start of 11 gives 11, 10, 01, 00.
- R9: The fourth step after a load returns `addr_o` to the start address and `beat_o` to 0. Further steps repeat the same four addresses.
- R10: The order is taken from `order_i` at each advancing edge. Changing it mid-burst remaps the next beat against the original start value and does not restart the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| proc_go_i | input | 1 | Processor-side start strobe, active high |
| ctrl_go_i | input | 1 | Controller-side start strobe, active high |
| adv_i | input | 1 | Advance one beat when high; wait when low |
| order_i | input | 1 | Beat order: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst word address (registered) |
| beat_o | output | 2 | Current beat index (registered) |

## Verification
The assertions assume that the strobes, `adv_i` and `order_i` carry defined values at every sampled edge. They also assume that a burst starts only after reset has been released for at least one edge, because every property is gated on the previous cycle being out of reset. The stimulus changes inputs only half a period away from the active edge, so nothing is ever X at an edge. It starts every scenario with an explicit load, covering single strobes, both strobes together and a strobe together with advance. It also switches `order_i` in the middle of a burst, which exercises the case where the low bits no longer follow one order consistently.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } op_e;
endpackage

// File: rtl/bas_ctrl.sv
module bas_ctrl
  import bas_pkg::*;
(
  input  logic proc_go,
  input  logic ctrl_go,
  input  logic adv,
  output op_e  op
);
  // a start strobe wins over advance
  always_comb begin
    if (proc_go || ctrl_go) op = OP_LOAD;
    else if (adv)           op = OP_STEP;
    else                    op = OP_HOLD;
  end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  output logic [CNT_W-1:0] beat_q,
  output logic [CNT_W-1:0] beat_nxt
);
  always_comb begin
    case (op)
      OP_LOAD: beat_nxt = '0;
      OP_STEP: beat_nxt = beat_q + 1'b1;
      default: beat_nxt = beat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] beat,
  input  order_e           order,
  output logic [CNT_W-1:0] lo
);
  logic [CNT_W-1:0] lin_lo;
  logic [CNT_W-1:0] ilv_lo;

  assign lin_lo = start_lo + beat;   // wraps modulo burst length
  assign ilv_lo = start_lo ^ beat;

  always_comb lo = (order == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BURST_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         proc_go_i,
  input  logic                         ctrl_go_i,
  input  logic                         adv_i,
  input  logic                         order_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [ADDR_W-1:0]            addr_o,
  output logic [$clog2(BURST_LEN)-1:0] beat_o
);
  localparam int CNT_W = $clog2(BURST_LEN);

  op_e              op;
  logic [CNT_W-1:0] beat_q;
  logic [CNT_W-1:0] beat_nxt;
  logic [CNT_W-1:0] lo_nxt;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;

  bas_ctrl u_ctrl (
    .proc_go (proc_go_i),
    .ctrl_go (ctrl_go_i),
    .adv     (adv_i),
    .op      (op)
  );

  bas_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .beat_q   (beat_q),
    .beat_nxt (beat_nxt)
  );

  bas_order_map #(.CNT_W(CNT_W)) u_map (
    .start_lo (base_q[CNT_W-1:0]),
    .beat     (beat_nxt),
    .order    (order_e'(order_i)),
    .lo       (lo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          base_q <= addr_i;
          addr_q <= addr_i;
        end
        OP_STEP: addr_q <= {base_q[ADDR_W-1:CNT_W], lo_nxt};
        default: ;
      endcase
    end
  end

  assign addr_o = addr_q;
  assign beat_o = beat_q;
endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_go_i,
  input logic              ctrl_go_i,
  input logic              adv_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  beat_o,
  input logic [ADDR_W-1:0] base_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (addr_o == '0 && beat_o == '0));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(proc_go_i || ctrl_go_i)) |->
      (addr_o == $past(addr_i) && beat_o == '0));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!proc_go_i && !ctrl_go_i && !adv_i)) |->
      ($stable(addr_o) && $stable(beat_o)));

  // R4
  step_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!proc_go_i && !ctrl_go_i && adv_i)) |->
      (beat_o == CNT_W'($past(beat_o) + 1'b1)));

  // R6
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!proc_go_i && !ctrl_go_i)) |->
      (addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W])));

  // R7
  linear_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!proc_go_i && !ctrl_go_i && adv_i && !order_i)) |->
      (CNT_W'(addr_o[CNT_W-1:0] - beat_o) == base_q[CNT_W-1:0]));

  // R8
  ilv_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!proc_go_i && !ctrl_go_i && adv_i && order_i)) |->
      ((addr_o[CNT_W-1:0] ^ beat_o) == base_q[CNT_W-1:0]));
endmodule

bind burst_addr_seq bas_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .proc_go_i (proc_go_i),
  .ctrl_go_i (ctrl_go_i),
  .adv_i     (adv_i),
  .order_i   (order_i),
  .addr_i    (addr_i),
  .addr_o    (addr_o),
  .beat_o    (beat_o),
  .base_q    (base_q)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          proc_go_i = 1'b0;
  logic          ctrl_go_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          order_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference state
  int m_base = 0;
  int m_beat = 0;
  int m_addr = 0;
  int m_prev_order = -1;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) u0 (
    .clk(clk), .rst(rst), .proc_go_i(proc_go_i), .ctrl_go_i(ctrl_go_i),
    .adv_i(adv_i), .order_i(order_i), .addr_i(addr_i),
    .addr_o(addr_o), .beat_o(beat_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // apply one cycle of inputs, update the model at the edge, compare after it
  task automatic cyc(input bit r, input bit pg, input bit cg, input bit adv,
                     input bit ord, input int a);
    string tag;
    string btag;
    rst = r; proc_go_i = pg; ctrl_go_i = cg; adv_i = adv; order_i = ord;
    addr_i = AW'(a);
    @(posedge clk);
    btag = "R4";
    if (r) begin
      m_base = 0; m_beat = 0; m_addr = 0; tag = "R1"; btag = "R1";
    end else if (pg || cg) begin
      m_base = a; m_beat = 0; m_addr = a;
      tag = adv ? "R3" : "R2"; btag = tag;
    end else if (adv) begin
      m_beat = (m_beat + 1) % 4;
      if (ord) m_addr = (m_base & ~3) | ((m_base & 3) ^ m_beat);
      else     m_addr = (m_base & ~3) | (((m_base & 3) + m_beat) % 4);
      if (m_beat == 0)                                  tag = "R9";
      else if (m_prev_order >= 0 && m_prev_order != int'(ord)) tag = "R10";
      else                                              tag = ord ? "R8" : "R7";
    end else begin
      tag = "R5"; btag = "R5";
    end
    if (!r && !pg && !cg && adv) m_prev_order = int'(ord);
    if (pg || cg || r) m_prev_order = -1;
    @(negedge clk);
    check(btag, int'(beat_o), m_beat);
    check("R6", int'(addr_o) >> 2, m_addr >> 2);
    check(tag, int'(addr_o) & 3, m_addr & 3);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, 0, 0, 0, 0, 0);           // R1 reset state
    cyc(1, 1, 0, 1, 0, 'h1ffff);     // R1 reset beats strobe
    // R7 linear from 01, R9 wrap
    cyc(0, 1, 0, 0, 0, 'h0a5c1);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 0, 'h00002);
    // R5 wait mid burst
    cyc(0, 0, 0, 0, 0, 'h1ffff);
    cyc(0, 0, 0, 0, 1, 'h1ffff);
    cyc(0, 0, 0, 1, 0, 0);
    // R3 controller strobe with advance, R8 interleave from 10
    cyc(0, 0, 1, 1, 1, 'h13572);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 1, 0);
    // R8 interleave from 11, both strobes
    cyc(0, 1, 1, 0, 1, 'h0ff03);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, 0);
    // R10 order change mid burst
    cyc(0, 1, 0, 0, 0, 'h00001);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 0);
    // R1 reset mid burst
    cyc(1, 0, 0, 1, 0, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int rv = int'($urandom);
      cyc((rv % 97) == 0, (rv >> 3) % 9 == 0, (rv >> 7) % 11 == 0,
          ((rv >> 11) & 3) != 0, (rv >> 13) & 1, int'($urandom) & 'h1ffff);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule